// File: doc/BRIEF.md
# Latch-or-Register Bus Path Stage

This block is one direction of a bidirectional registered bus path. It carries two independent 9-bit lanes. Each lane holds eight data bits and one parity bit, and the parity bit is stored exactly like a data bit. Every storage bit can behave in one of three ways:

- as a transparent latch, while the shared latch enable is high;
- as an edge-triggered register, when its lane's active-low clock enable is low at a rising clock edge;
- as a hold, in every other case.

Both lanes share one clock and one latch enable. Each lane has its own clock enable.

The stored value appears at the output together with a drive-enable flag. The flag and the data are separate signals, not a tri-state pin. While the flag is low the data output is forced to zero. An integrator instantiates one stage per direction. The tri-state pad driver can be fed from `oe_o` and `data_o`.

Top module: `bpath_stage`

## Requirements
- R1: While `le_i` is high, each lane of the stored value equals the matching lane of `data_i` in the same cycle, whatever `clk_i` and `clk_en_ni` do.
- R2: While `le_i` is low, a lane whose `clk_en_ni` bit is low loads its slice of `data_i` at the rising edge of `clk_i`. The new value is visible after that edge.
- R3: While `le_i` is low, a lane whose `clk_en_ni` bit is high keeps its value across clock edges, even when `data_i` changes.
- R4: When `le_i` falls while the clock is low, each lane keeps the value it had at the fall. Later input changes do not disturb it. This latched value wins over any older register capture, and a later register capture wins over it.
- R5: Lane 0 is `data_i[8:0]` and is controlled by `clk_en_ni[0]`. Lane 1 is `data_i[17:9]` and is controlled by `clk_en_ni[1]`. In each lane the parity bit is the top bit (bit 8 of the lane). Enabling one lane never changes the other lane.
- R6: `oe_o` is always the inverse of `oe_ni`. While `oe_ni` is high, `data_o` is all zeros and the stored value is preserved. While `oe_ni` is low, `data_o` shows the stored value.
- R7: An active-low asynchronous `rst_ni` clears all 18 storage bits to zero. With `le_i` low and `oe_ni` low, `data_o` reads zero during reset and stays zero until a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Capture clock shared by both lanes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 18 | Two 9-bit lanes, lane 1 in the upper half |
| le_i | input | 1 | Latch enable, high makes storage transparent |
| clk_en_ni | input | 2 | Per-lane clock enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| data_o | output | 18 | Stored value when driven, zero otherwise |
| oe_o | output | 1 | High when the output is driven |

## Verification
Some properties are checked by assertions on every clock edge:
- transparency while the latch enable is high;
- that a clock-enabled edge loads the lane;
- that a disabled lane stays stable;
- the inverse relation between the two enables, and the zero data while not driven;
- the zero state during reset.

Other behaviour depends on edges that happen between clock edges, or on the order of events. Only the bench scenarios show it:
- keeping a value after the latch enable falls in the low clock phase;
- which of latch or register holds the newer value;
- lane independence under split enables;
- a state hidden behind a disabled output staying intact.

// File: rtl/bpath_pkg.sv
package bpath_pkg;
  localparam int unsigned BP_LANE_W = 9;
  localparam int unsigned BP_LANES  = 2;
  localparam int unsigned BP_WIDTH  = BP_LANE_W * BP_LANES;
endpackage

// File: rtl/bpath_lane.sv
module bpath_lane #(
  parameter int unsigned LANE_W = bpath_pkg::BP_LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic              clk_en_ni,
  input  logic [LANE_W-1:0] d_i,
  output logic [LANE_W-1:0] q_o
);
  logic [LANE_W-1:0] lat_q;
  logic [LANE_W-1:0] ff_q;
  logic              ff_sel_q;
  logic              capture;

  assign capture = !le_i && !clk_en_ni;

  // level-sensitive path
  always_latch begin
    if (!rst_ni)   lat_q = '0;
    else if (le_i) lat_q = d_i;
  end

  // edge-sensitive path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ff_q <= '0;
    else if (capture) ff_q <= d_i;
  end

  // remembers which path holds the newest value; transparency clears it at once
  always_ff @(posedge clk_i or negedge rst_ni or posedge le_i) begin
    if (!rst_ni)      ff_sel_q <= 1'b0;
    else if (le_i)    ff_sel_q <= 1'b0;
    else if (capture) ff_sel_q <= 1'b1;
  end

  always_comb begin
    if (le_i)          q_o = d_i;
    else if (ff_sel_q) q_o = ff_q;
    else               q_o = lat_q;
  end

  // R2
  a_r2_capture_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !clk_en_ni) |=> (le_i || q_o == $past(d_i)));

  // R3
  a_r3_disabled_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && clk_en_ni) |=> (le_i || $stable(q_o)));
endmodule

// File: rtl/bpath_drive.sv
module bpath_drive #(
  parameter int unsigned WIDTH = bpath_pkg::BP_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] stored_i,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] data_o,
  output logic             oe_o
);
  assign oe_o   = ~oe_ni;
  assign data_o = oe_o ? stored_i : '0;

  // R6
  a_r6_flag_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o != oe_ni);

  // R6
  a_r6_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> data_o == '0);
endmodule

// File: rtl/bpath_stage.sv
module bpath_stage
  import bpath_pkg::*;
#(
  parameter int unsigned LANE_W = BP_LANE_W,
  parameter int unsigned LANES  = BP_LANES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANE_W*LANES-1:0] data_i,
  input  logic                    le_i,
  input  logic [LANES-1:0]        clk_en_ni,
  input  logic                    oe_ni,
  output logic [LANE_W*LANES-1:0] data_o,
  output logic                    oe_o
);
  localparam int unsigned WIDTH = LANE_W * LANES;

  logic [WIDTH-1:0] stored;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bpath_lane #(.LANE_W(LANE_W)) lane_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .le_i     (le_i),
      .clk_en_ni(clk_en_ni[g]),
      .d_i      (data_i[g*LANE_W +: LANE_W]),
      .q_o      (stored[g*LANE_W +: LANE_W])
    );
  end

  bpath_drive #(.WIDTH(WIDTH)) drive_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stored_i(stored),
    .oe_ni   (oe_ni),
    .data_o  (data_o),
    .oe_o    (oe_o)
  );

  // R1
  a_r1_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && !oe_ni) |-> data_o == data_i);

  // R7
  a_r7_reset_clear: assert property (@(posedge clk_i)
    (!rst_ni && !le_i) |-> stored == '0);
endmodule

// File: tb/bpath_stage_tb_top.sv
`timescale 1ns/1ps
module bpath_stage_tb_top;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int W  = LW * NL;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  data_i = '0;
  logic          le_i = 1'b0;
  logic [NL-1:0] clk_en_ni = '1;
  logic          oe_ni = 1'b0;
  logic [W-1:0]  data_o;
  logic          oe_o;

  int compared = 0;
  int mismatched = 0;
  logic [W-1:0] m_store = '0;

  always #2.5 clk_i = ~clk_i;

  bpath_stage dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .le_i(le_i),
    .clk_en_ni(clk_en_ni), .oe_ni(oe_ni), .data_o(data_o), .oe_o(oe_o)
  );

  task automatic check(string tag);
    logic [W-1:0] exp_d;
    exp_d = oe_ni ? '0 : m_store;
    compared++;
    if (data_o !== exp_d || oe_o !== ~oe_ni) begin
      mismatched++;
      $display("FAIL %s: data_o=%h oe_o=%b expected data_o=%h oe_o=%b",
               tag, data_o, oe_o, exp_d, ~oe_ni);
    end
  endtask

  task automatic step(input logic [W-1:0] d, input logic le,
                      input logic [NL-1:0] cen, input logic oen, input string tag);
    @(negedge clk_i);
    data_i = d; le_i = le; clk_en_ni = cen; oe_ni = oen;
    #1;
    if (le) m_store = d;
    check(tag);
    @(posedge clk_i);
    #1;
    if (!le)
      for (int i = 0; i < NL; i++)
        if (!cen[i]) m_store[i*LW +: LW] = d[i*LW +: LW];
    check(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk_i);
    le_i = 1'b0; oe_ni = 1'b0; rst_ni = 1'b0;
    #1;
    m_store = '0;
    check(tag);
    @(posedge clk_i);
    #1;
    check(tag);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R7: state under reset
    #1; check("R7 reset");
    @(posedge clk_i); #1; check("R7 reset");
    @(negedge clk_i); rst_ni = 1'b1;
    step(18'h0_0000, 1'b0, 2'b11, 1'b0, "R7 after release");
    // R1: transparent, clock enables ignored
    step({9'h1A5, 9'h05C}, 1'b1, 2'b11, 1'b0, "R1 transparent cen off");
    step({9'h0F3, 9'h1C0}, 1'b1, 2'b00, 1'b0, "R1 transparent cen on");
    // R4: latch fall keeps value, then input changes
    step({9'h0F3, 9'h1C0}, 1'b0, 2'b11, 1'b0, "R4 latch fall");
    step({9'h155, 9'h0AA}, 1'b0, 2'b11, 1'b0, "R4 R3 hold after fall");
    // R2: both lanes capture
    step({9'h12E, 9'h1FF}, 1'b0, 2'b00, 1'b0, "R2 capture both");
    // R3: both lanes disabled
    step({9'h000, 9'h000}, 1'b0, 2'b11, 1'b0, "R3 hold both");
    // R5: lane 0 only, then lane 1 only, parity bit set
    step({9'h100, 9'h101}, 1'b0, 2'b10, 1'b0, "R5 lane0 only");
    step({9'h1F0, 9'h00F}, 1'b0, 2'b01, 1'b0, "R5 lane1 only");
    // R6: output off, state hidden but preserved
    step({9'h033, 9'h144}, 1'b0, 2'b11, 1'b1, "R6 outputs off");
    step({9'h033, 9'h144}, 1'b0, 2'b11, 1'b0, "R6 outputs back on");
    // R4: transparency supersedes an earlier capture
    step({9'h0C3, 9'h13C}, 1'b1, 2'b11, 1'b0, "R4 R1 reopen");
    step({9'h0C3, 9'h13C}, 1'b0, 2'b11, 1'b0, "R4 close over capture");
    step({9'h1AB, 9'h0CD}, 1'b0, 2'b11, 1'b0, "R4 latch wins over old capture");
    // R4: later capture supersedes latched value
    step({9'h077, 9'h188}, 1'b0, 2'b00, 1'b0, "R4 R2 capture over latch");
    step({9'h1FF, 9'h1FF}, 1'b0, 2'b11, 1'b0, "R3 hold after capture");
    // R7: reset mid-run
    do_reset("R7 mid-run reset");
    step({9'h1EE, 9'h0DD}, 1'b0, 2'b11, 1'b0, "R7 stays zero");
    step({9'h1EE, 9'h0DD}, 1'b0, 2'b00, 1'b0, "R2 after reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule